// File: doc/BRIEF.md
# Multi-Target Serial-Slave Configuration Sequencer

This block drives the configuration pins of one to four downstream programmable devices and loads the same configuration image into each of them in turn. A session begins with a start pulse. The sequencer pulls the program line low and waits for the device's init handshake to fall. It then releases program and waits for init to rise again. After that it opens each target in order. For the open target it asserts that target's active-low select and sets that target's interrupt-enable bit. It then streams the image to it as byte-wide writes on the upper lane of a 16-bit write port.

Once every target has been loaded, the sequencer issues four dummy reads at each target's base address. These reads supply the extra startup clocks. It then waits for the shared done pin. Each of the three handshake waits has its own timeout and its own error code. Success and failure are held on status outputs until the next session.

The image arrives as 32-bit words over a valid/ready stream. The stream is replayed from its first word for every target, so the upstream source must be able to rewind. Image storage and integrity checking belong elsewhere.

Top module: `slave_cfg_sequencer`

## Requirements
- R1: On a start pulse while idle, `prog_o` goes low and the block waits for the synchronised init pin to read low. If the pin does not fall within the timeout, the session ends with `err_o`=1 and `err_code_o`=1 ("init never fell"). `prog_o` stays low and no write is issued.
- R2: Once init reads low, `prog_o` returns high and the block waits for init to read high. If that times out, `prog_o` is driven low again and the session ends with `err_code_o`=2 ("init never released").
- R3: Each accepted 32-bit word produces four consecutive write strobes. The bytes go out most significant first. Each byte sits on `bus_wdata_o[15:8]` and `bus_wdata_o[7:0]` is zero.
- R4: For an image of B bytes, each target receives floor(B/4)+1 words. B is sampled from `img_bytes_i` at start.
- R5: Targets are loaded in order k = 0 .. N_TGT-1. While target k is open, only `cs_n_o[N_TGT-1-k]` is low and only `irq_en_o[N_TGT-1-k]` is high. Both are released (all selects high, all enables low) before the next target opens.
- R6: Every write and read for target k carries `bus_addr_o` = k × REGION_STEP (0x100000 by default).
- R7: After the last target's stream, exactly four read strobes are issued per target, in target order, with all selects released. Writes and reads never coincide.
- R8: After the reads, the done wait starts with a fresh timeout. If done reads high, `ok_o`=1 and `prog_o` stays high. If it times out, `prog_o` goes low and `err_code_o`=3.
- R9: The init-fall and init-rise waits share one timeout window counted from the start of the session. A response that is late in each wait alone but exceeds the window in total ends with code 2. A wait ends with its error TIMEOUT+1 cycles after its window opens, and never earlier.
- R10: `word_ready_o` is high only while a target is open and the sequencer waits for the next word. A low `word_valid_i` stalls the stream without losing or repeating data.
- R11: `busy_o` is high from the cycle after start until the session ends. A start pulse during a session is ignored. A new session clears `ok_o`, `err_o` and `err_code_o`.
- R12: After reset, `prog_o`=1, all selects are high, all enables are low, and no strobe or status output is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a session (ignored while busy) |
| img_bytes_i | input | SIZE_W | Image size in bytes, sampled at start |
| word_valid_i | input | 1 | Image word available |
| word_data_i | input | 32 | Image word |
| word_ready_o | output | 1 | Word accepted on this cycle when valid |
| init_pin_i | input | 1 | Device init handshake (asynchronous) |
| done_pin_i | input | 1 | Device done indication (asynchronous) |
| prog_o | output | 1 | Program line, low = clear/restart devices |
| cs_n_o | output | N_TGT | Per-target select, active low |
| irq_en_o | output | N_TGT | Per-target interrupt enable, active high |
| bus_addr_o | output | ADDR_W | Base address of the current target |
| bus_wdata_o | output | 16 | Write data, byte on bits 15:8 |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Dummy read strobe |
| busy_o | output | 1 | Session in progress |
| ok_o | output | 1 | Last session succeeded |
| err_o | output | 1 | Last session failed |
| err_code_o | output | 2 | 0 none, 1 init never fell, 2 init never released, 3 done timeout |

## Verification
The hardest case to reach from the ports is a failure in the shared window of the first two waits. In that case neither the init fall nor the init release is late on its own, yet together they use up the window. The bench's device model answers each program edge after its own programmable delay. Picking two delays that each fit but whose sum does not produces the code-2 abort. A long done delay after a long stream shows that the done wait restarts its window. A second start pulse during a stalled stream shows that restarts are ignored.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_INIT_LO,
    S_INIT_HI,
    S_ARM,
    S_LOAD,
    S_WRITE,
    S_RELEASE,
    S_DUMMY,
    S_DONE
  } seq_state_t;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_FALL = 2'd1;
  localparam logic [1:0] ERR_INIT_RISE = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

  // words streamed per target for an image of nbytes bytes
  function automatic logic [31:0] words_for_size(input logic [31:0] nbytes);
    return (nbytes >> 2) + 32'd1;
  endfunction

  // byte 'lane' (0 = most significant) of word, placed on the upper half
  function automatic logic [15:0] lane_byte(input logic [31:0] word, input logic [1:0] lane);
    logic [31:0] sh;
    sh = word << (8 * lane);
    return {sh[31:24], 8'h00};
  endfunction

  // base address of target idx
  function automatic logic [31:0] region_base(input logic [31:0] idx, input logic [31:0] step);
    return idx * step;
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (en_i && cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = (cnt_q == LIMIT);

  // R9
  expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !clr_i) |=> expired_o);
  // R9
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !expired_o);
endmodule

// File: rtl/cfg_byte_lane.sv
module cfg_byte_lane
  import cfgseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        step_i,
  output logic [15:0] wdata_o,
  output logic        last_o
);
  logic [31:0] word_q;
  logic [1:0]  lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lane_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      lane_q <= '0;
    end else if (step_i) begin
      lane_q <= lane_q + 2'd1;
    end
  end

  assign wdata_o = lane_byte(word_q, lane_q);
  assign last_o  = (lane_q == 2'd3);

  // R3
  lane_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && last_o) |=> (lane_q == 2'd0));
  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i) |=> $stable(word_q));
endmodule

// File: rtl/slave_cfg_sequencer.sv
module slave_cfg_sequencer
  import cfgseq_pkg::*;
#(
  parameter int          N_TGT       = 2,
  parameter int          TIMEOUT     = 1000,
  parameter int          SIZE_W      = 20,
  parameter int          ADDR_W      = 24,
  parameter logic [31:0] REGION_STEP = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] img_bytes_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_data_i,
  output logic              word_ready_o,
  input  logic              init_pin_i,
  input  logic              done_pin_i,
  output logic              prog_o,
  output logic [N_TGT-1:0]  cs_n_o,
  output logic [N_TGT-1:0]  irq_en_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;
  localparam logic [TGT_W-1:0] LAST_TGT = TGT_W'(N_TGT - 1);

  seq_state_t        state_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [SIZE_W-1:0] nwords_q, wcnt_q;
  logic [1:0]        rdc_q;
  logic              prog_q, ok_q, err_q;
  logic [1:0]        code_q;
  logic [N_TGT-1:0]  cs_n_q, irq_q, sel_mask;

  logic init_s, done_s, expired;
  logic [15:0] lane_data;
  logic        lane_last;

  // named internal events
  logic ev_start, ev_take, ev_byte, ev_word_end, ev_stream_end, ev_last_tgt;
  logic ev_rd_group_end, ev_tmr_clr, ev_tmr_en;

  cfg_pin_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({done_pin_i, init_pin_i}),
    .sync_o({done_s, init_s})
  );

  cfg_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clr_i(ev_tmr_clr), .en_i(ev_tmr_en),
    .expired_o(expired)
  );

  cfg_byte_lane u_lane (
    .clk(clk), .rst_n(rst_n),
    .load_i(ev_take), .word_i(word_data_i),
    .step_i(ev_byte),
    .wdata_o(lane_data), .last_o(lane_last)
  );

  for (genvar i = 0; i < N_TGT; i++) begin : g_sel
    assign sel_mask[i] = (tgt_q == TGT_W'(N_TGT - 1 - i));
  end

  assign ev_start        = (state_q == S_IDLE) && start_i;
  assign ev_take         = (state_q == S_LOAD) && word_valid_i;
  assign ev_byte         = (state_q == S_WRITE);
  assign ev_word_end     = ev_byte && lane_last;
  assign ev_stream_end   = ev_word_end && (wcnt_q == nwords_q - SIZE_W'(1));
  assign ev_last_tgt     = (tgt_q == LAST_TGT);
  assign ev_rd_group_end = (state_q == S_DUMMY) && (rdc_q == 2'd3);
  assign ev_tmr_clr      = ev_start || (ev_rd_group_end && ev_last_tgt);
  assign ev_tmr_en       = (state_q == S_INIT_LO) || (state_q == S_INIT_HI) ||
                           (state_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      tgt_q    <= '0;
      nwords_q <= '0;
      wcnt_q   <= '0;
      rdc_q    <= '0;
      prog_q   <= 1'b1;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= ERR_NONE;
      cs_n_q   <= '1;
      irq_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_INIT_LO;
          prog_q   <= 1'b0;
          ok_q     <= 1'b0;
          err_q    <= 1'b0;
          code_q   <= ERR_NONE;
          nwords_q <= SIZE_W'(words_for_size(32'(img_bytes_i)));
        end
        S_INIT_LO: if (!init_s) begin
          prog_q  <= 1'b1;
          state_q <= S_INIT_HI;
        end else if (expired) begin
          err_q   <= 1'b1;
          code_q  <= ERR_INIT_FALL;
          state_q <= S_IDLE;
        end
        S_INIT_HI: if (init_s) begin
          tgt_q   <= '0;
          state_q <= S_ARM;
        end else if (expired) begin
          prog_q  <= 1'b0;
          err_q   <= 1'b1;
          code_q  <= ERR_INIT_RISE;
          state_q <= S_IDLE;
        end
        S_ARM: begin
          cs_n_q  <= ~sel_mask;
          irq_q   <= sel_mask;
          wcnt_q  <= '0;
          state_q <= S_LOAD;
        end
        S_LOAD: if (word_valid_i) state_q <= S_WRITE;
        S_WRITE: if (ev_stream_end) begin
          state_q <= S_RELEASE;
        end else if (ev_word_end) begin
          wcnt_q  <= wcnt_q + SIZE_W'(1);
          state_q <= S_LOAD;
        end
        S_RELEASE: begin
          cs_n_q <= '1;
          irq_q  <= '0;
          if (ev_last_tgt) begin
            tgt_q   <= '0;
            rdc_q   <= '0;
            state_q <= S_DUMMY;
          end else begin
            tgt_q   <= tgt_q + TGT_W'(1);
            state_q <= S_ARM;
          end
        end
        S_DUMMY: begin
          rdc_q <= rdc_q + 2'd1;
          if (ev_rd_group_end) begin
            if (ev_last_tgt) state_q <= S_DONE;
            else             tgt_q   <= tgt_q + TGT_W'(1);
          end
        end
        S_DONE: if (done_s) begin
          ok_q    <= 1'b1;
          state_q <= S_IDLE;
        end else if (expired) begin
          prog_q  <= 1'b0;
          err_q   <= 1'b1;
          code_q  <= ERR_DONE;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign word_ready_o = (state_q == S_LOAD);
  assign prog_o       = prog_q;
  assign cs_n_o       = cs_n_q;
  assign irq_en_o     = irq_q;
  assign bus_addr_o   = ADDR_W'(region_base(32'(tgt_q), REGION_STEP));
  assign bus_wr_o     = ev_byte;
  assign bus_rd_o     = (state_q == S_DUMMY);
  assign bus_wdata_o  = ev_byte ? lane_data : 16'h0000;
  assign busy_o       = (state_q != S_IDLE);
  assign ok_o         = ok_q;
  assign err_o        = err_q;
  assign err_code_o   = code_q;

  // R5
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n_q) <= 1);
  // R5
  irq_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == ~cs_n_q);
  // R10
  ready_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> !(&cs_n_q));
  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_o && bus_rd_o));
  // R7
  rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> (&cs_n_q));
  // R8
  ok_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> prog_o);
  // R1
  err_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !prog_o);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (busy_o && !ok_o && !err_o));
endmodule

// File: tb/test_slave_cfg_sequencer.sv
module test_slave_cfg_sequencer;
  localparam int N   = 3;
  localparam int TMO = 40;
  localparam int SW  = 20;
  localparam int AW  = 24;
  localparam logic [31:0] STEP = 32'h0010_0000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [SW-1:0] img_bytes = '0;
  logic word_valid = 0;
  logic [31:0] word_data;
  logic word_ready;
  logic init_pin, done_pin;
  logic prog, bus_wr, bus_rd, busy, ok, err;
  logic [N-1:0] cs_n, irq_en;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0] err_code;

  always #5 clk = ~clk;

  slave_cfg_sequencer #(.N_TGT(N), .TIMEOUT(TMO), .SIZE_W(SW), .ADDR_W(AW),
                        .REGION_STEP(STEP)) i_slave_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_bytes_i(img_bytes),
    .word_valid_i(word_valid), .word_data_i(word_data), .word_ready_o(word_ready),
    .init_pin_i(init_pin), .done_pin_i(done_pin), .prog_o(prog),
    .cs_n_o(cs_n), .irq_en_o(irq_en), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_wr_o(bus_wr), .bus_rd_o(bus_rd),
    .busy_o(busy), .ok_o(ok), .err_o(err), .err_code_o(err_code));

  int checks = 0, errors = 0, cyc = 0;

  // device model controls
  logic fall_en, rise_en, done_en, stall;
  int fall_dly, rise_dly, done_dly, fc, rc, dc;
  // monitor tallies
  int wr_seen, rd_seen, cur_nw, bad_data, bad_sel, bad_addr, bad_rd, bad_rdy;
  int ptr;

  function automatic logic [31:0] img_word(input int w);
    return {8'(8'hA0 + w), 8'(8'h51 + 2*w), 8'(3*w), 8'(8'hF0 ^ w)};
  endfunction

  assign word_data = img_word(ptr);

  always @(posedge clk) begin
    if (!rst_n || (&cs_n)) ptr <= 0;
    else if (word_valid && word_ready) ptr <= ptr + 1;
  end

  always @(negedge clk) begin
    cyc++;
    word_valid <= !stall || (cyc % 3 != 1);
    if (!rst_n) begin
      init_pin <= 1; done_pin <= 0; fc = 0; rc = 0; dc = 0;
    end else begin
      if (!prog && init_pin && fall_en) begin
        if (fc >= fall_dly) begin init_pin <= 0; fc = 0; end else fc++;
      end
      if (prog && !init_pin && rise_en) begin
        if (rc >= rise_dly) begin init_pin <= 1; rc = 0; end else rc++;
      end
      if (!prog) begin done_pin <= 0; dc = 0; end
      else if (done_en && rd_seen >= 4*N && !done_pin) begin
        if (dc >= done_dly) done_pin <= 1; else dc++;
      end
      if (word_ready && (&cs_n)) bad_rdy++;
      if (bus_wr) begin : mon_wr
        int t, w, b;
        logic [31:0] ew;
        t = wr_seen / (cur_nw * 4);
        w = (wr_seen / 4) % cur_nw;
        b = wr_seen % 4;
        ew = img_word(w);
        if (bus_wdata !== {ew[31-8*b -: 8], 8'h00}) bad_data++;
        if (cs_n !== ~(N'(1) << (N-1-t)) || irq_en !== (N'(1) << (N-1-t))) bad_sel++;
        if (bus_addr !== AW'(t * STEP)) bad_addr++;
        wr_seen++;
      end
      if (bus_rd) begin
        if (bus_addr !== AW'((rd_seen / 4) * STEP) || !(&cs_n) || wr_seen != N*cur_nw*4)
          bad_rd++;
        rd_seen++;
      end
    end
  end

  task automatic chk(input logic cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_model(input logic fe, input logic re, input logic de,
                           input int fd, input int rd, input int dd, input logic st);
    fall_en = fe; rise_en = re; done_en = de;
    fall_dly = fd; rise_dly = rd; done_dly = dd; stall = st;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; start = 0;
    wr_seen = 0; rd_seen = 0; bad_data = 0; bad_sel = 0; bad_addr = 0;
    bad_rd = 0; bad_rdy = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic pulse_start(input int bytes);
    @(posedge clk); #1;
    img_bytes = SW'(bytes);
    cur_nw = (bytes - bytes % 4) / 4 + 1;
    wr_seen = 0; rd_seen = 0;
    start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 20000) begin @(posedge clk); #2; n++; end
    chk(!busy, "R11", "session ends", int'(busy), 0);
  endtask

  task automatic t_reset();
    do_reset(); #2;
    chk(prog === 1 && (&cs_n) && irq_en === '0, "R12", "pins after reset",
        int'({prog, cs_n}), int'({1'b1, {N{1'b1}}}));
    chk(!bus_wr && !bus_rd && !busy && !ok && !err && !word_ready && err_code == 0,
        "R12", "strobes/status after reset", int'({bus_wr, bus_rd, busy, ok, err}), 0);
  endtask

  task automatic t_good(input int bytes, input logic st, input int fd, input int rd,
                        input int dd, input logic restart);
    do_reset();
    set_model(1, 1, 1, fd, rd, dd, st);
    pulse_start(bytes);
    #1 chk(busy && !prog, "R1", "program low while session runs", int'(prog), 0);
    if (restart) begin
      repeat (60) @(posedge clk);
      #1 start = 1; @(posedge clk); #1 start = 0;
    end
    wait_idle();
    chk(ok && !err && err_code == 0, "R8", "success status", int'(err_code), 0);
    chk(prog === 1, "R8", "program high after success", int'(prog), 1);
    chk(wr_seen == N * cur_nw * 4, "R4", "write count", wr_seen, N * cur_nw * 4);
    chk(bad_data == 0, "R3", "byte order and lane", bad_data, 0);
    chk(bad_sel == 0, "R5", "select and enable per target", bad_sel, 0);
    chk(bad_addr == 0, "R6", "write address per target", bad_addr, 0);
    chk(rd_seen == 4 * N && bad_rd == 0, "R7", "dummy reads", rd_seen, 4 * N);
    chk(bad_rdy == 0 && (&cs_n) && irq_en == '0, "R10", "ready only with target open",
        bad_rdy, 0);
  endtask

  task automatic t_init_start();
    do_reset();
    set_model(0, 1, 1, 0, 0, 0, 0);
    pulse_start(8);
    repeat (TMO - 5) @(posedge clk); #2;
    chk(busy && !err, "R9", "no abort before timeout", int'(err), 0);
    wait_idle();
    chk(err && err_code == 2'd1, "R1", "init-fall error code", int'(err_code), 1);
    chk(prog === 0 && wr_seen == 0, "R1", "program low, no writes", wr_seen, 0);
  endtask

  task automatic t_init_exit(input int fd, input int rd, input logic re, input string req);
    do_reset();
    set_model(1, re, 1, fd, rd, 0, 0);
    pulse_start(8);
    wait_idle();
    chk(err && err_code == 2'd2, req, "init-release error code", int'(err_code), 2);
    chk(prog === 0 && wr_seen == 0, req, "program low after abort", int'(prog), 0);
  endtask

  task automatic t_done_timeout();
    do_reset();
    set_model(1, 1, 0, 2, 2, 0, 0);
    pulse_start(12);
    wait_idle();
    chk(err && err_code == 2'd3 && !ok, "R8", "done-timeout code", int'(err_code), 3);
    chk(prog === 0 && wr_seen == N * cur_nw * 4, "R8", "prog low, stream complete",
        wr_seen, N * cur_nw * 4);
  endtask

  task automatic t_status_clear();
    do_reset();
    set_model(0, 1, 1, 0, 0, 0, 0);
    pulse_start(4);
    wait_idle();
    fall_en = 1; fall_dly = 3; rise_dly = 3;
    pulse_start(4);
    #1 chk(!err && err_code == 0 && busy, "R11", "status cleared by new start",
           int'(err_code), 0);
    wait_idle();
    chk(ok && !err, "R11", "second session succeeds", int'(ok), 1);
  endtask

  initial begin
    set_model(1, 1, 1, 3, 3, 3, 0);
    cur_nw = 1; ptr = 0;
    t_reset();
    t_good(10, 0, 3, 3, 3, 0);      // 3 words per target
    t_good(0, 1, 2, 5, 1, 0);       // single word, stalled source
    t_good(7, 1, 4, 4, 2, 1);       // restart pulse mid-session ignored (R11)
    t_good(5, 0, 28, 2, 30, 0);     // late init fall, late done: R9 window per wait
    t_init_start();
    t_init_exit(2, 0, 0, "R2");     // init never released
    t_init_exit(20, 25, 1, "R9");   // each alone fits, sum exceeds shared window
    t_done_timeout();
    t_status_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule